// File: doc/BRIEF.md
# Multicore Snoop Unit Register Interface

This block is the register slave of a multicore coherency (snoop) unit. It sits on a simple 32-bit register bus: a request strobe, a write enable, an 8-bit byte address inside a 256-byte window, write data and read data. It exposes four word registers: a control word, a read-only configuration word derived from the number of cores, a power status word with one field per core, and a cache-invalidate word that reads zero and has no effect. All other offsets in the window are unimplemented. They read zero, discard writes and raise a one-cycle flag.

Byte and halfword accesses are legal on the bus. The block decodes only the word index, address bits 7:2, and always returns or accepts a full 32-bit word. Selecting the byte lanes is left to the bus side. A write anywhere in the power status word replaces the whole word, so there is no byte-lane merge.

The core count `NUM_CORES` must lie between 1 and 4. Any other value stops elaboration.

Top module: `snp_regif`

## Requirements
- R1: After reset, the control word and the power status word both read 0. The read data output is 0 and the unimplemented flag is low.
- R2: The configuration word, at word index 1 (byte offset 0x04), reads ((1 << N) - 1) << 4 | (N - 1), where N is `NUM_CORES`. For N = 4 this is 0x000000F3.
- R3: A write to the configuration word is ignored. It leaves that word and the other registers unchanged.
- R4: A write to the control word, at word index 0 (offset 0x00), stores all 32 bits, and a later read returns them.
- R5: A write to the power status word, at word index 2 (offsets 0x08 to 0x0B), replaces the whole 32-bit value, whichever byte offset within the word is used.
- R6: The invalidate word, at word index 3 (offset 0x0C), always reads 0. Writes to it change no register.
- R7: Any offset whose word index is 4 or above reads 0 and discards writes. The unimplemented flag goes high in the cycle after each such access, and only then.
- R8: Address bits 1:0 play no part in register selection. An access at any byte of a word reaches that word.
- R9: Read data is registered. It shows the addressed word in the cycle after a read request and holds that value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address in the 256-byte window |
| bus_wdata | input | 32 | Write data, full word |
| bus_rdata | output | 32 | Registered read data |
| unimp_pulse | output | 1 | High for one cycle after an access to an unimplemented offset |

## Verification
Directed accesses first hit each implemented word at its base offset and at misaligned byte offsets. Comparing these tells apart decoding on the word index from decoding on the full byte address, and shows whether a power status write replaces the word or merges byte lanes. Writes to the configuration and invalidate words are followed by reads of every register, which separates a real no-op from a write that lands in the wrong register. A seeded random mix of reads and writes over the whole window, checked against a bench model, then exercises the unimplemented region, back-to-back flag pulses and read data held across writes.

// File: rtl/snp_pkg.sv
package snp_pkg;

    localparam int WORD_W     = 32;
    localparam int WIN_ADDR_W = 8;
    localparam int IDX_W      = WIN_ADDR_W - 2;
    localparam int NUM_SLOTS  = 4;
    localparam int MAX_CORES  = 4;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_CFG  = 2'd1,
        SLOT_PWR  = 2'd2,
        SLOT_INV  = 2'd3
    } slot_e;

    typedef struct packed {
        logic  valid;
        logic  wr;
        logic  hit;
        slot_e slot;
    } acc_t;

    function automatic logic [WORD_W-1:0] cfg_word(input int n);
        logic [WORD_W-1:0] mask;
        mask = (WORD_W'(1) << n) - WORD_W'(1);
        return (mask << 4) | WORD_W'(n - 1);
    endfunction

endpackage

// File: rtl/snp_decode.sv
module snp_decode
    import snp_pkg::*;
(
    input  logic                  req,
    input  logic                  we,
    input  logic [IDX_W-1:0]      word_idx,
    output acc_t                  acc
);
    always_comb begin
        acc.valid = req;
        acc.wr    = we;
        acc.hit   = (word_idx < IDX_W'(NUM_SLOTS));
        acc.slot  = slot_e'(word_idx[1:0]);
    end
endmodule

// File: rtl/snp_store.sv
module snp_store
    import snp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] pwr_q
);
    logic wr_ok;
    assign wr_ok = acc.valid && acc.wr && acc.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pwr_q  <= '0;
        end else if (wr_ok) begin
            case (acc.slot)
                SLOT_CTRL: ctrl_q <= wdata;
                SLOT_PWR:  pwr_q  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/snp_readback.sv
module snp_readback
    import snp_pkg::*;
#(
    parameter logic [WORD_W-1:0] CFG_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [WORD_W-1:0] ctrl_q,
    input  logic [WORD_W-1:0] pwr_q,
    output logic [WORD_W-1:0] rdata_q,
    output logic              unimp_q
);
    logic [WORD_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (acc.hit) begin
            case (acc.slot)
                SLOT_CTRL: sel = ctrl_q;
                SLOT_CFG:  sel = CFG_VAL;
                SLOT_PWR:  sel = pwr_q;
                default:   sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            unimp_q <= 1'b0;
        end else begin
            unimp_q <= acc.valid && !acc.hit;
            if (acc.valid && !acc.wr) rdata_q <= sel;
        end
    end
endmodule

// File: rtl/snp_regif.sv
module snp_regif
    import snp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  unimp_pulse
);
    localparam logic [WORD_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

    generate
        if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_count
            $error("snp_regif: NUM_CORES must be 1 to 4");
        end
    endgenerate

    acc_t              acc;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] pwr_q;
    logic [1:0]        unused_lane;

    assign unused_lane = bus_addr[1:0];

    snp_decode u_dec (
        .req      (bus_req),
        .we       (bus_we),
        .word_idx (bus_addr[WIN_ADDR_W-1:2]),
        .acc      (acc)
    );

    snp_store u_store (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .pwr_q  (pwr_q)
    );

    snp_readback #(.CFG_VAL(CFG_VAL)) u_rb (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .ctrl_q  (ctrl_q),
        .pwr_q   (pwr_q),
        .rdata_q (bus_rdata),
        .unimp_q (unimp_pulse)
    );
endmodule

// File: rtl/snp_regif_chk.sv
module snp_regif_chk
    import snp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [WIN_ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0]     bus_wdata,
    input logic [WORD_W-1:0]     bus_rdata,
    input logic                  unimp_pulse
);
    logic is_rd, far;
    assign is_rd = bus_req && !bus_we;
    assign far   = bus_addr[WIN_ADDR_W-1:2] >= IDX_W'(NUM_SLOTS);

    // R1: state right after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_rdata == '0 && !unimp_pulse));

    // R2: configuration word
    a_r2_cfg_read: assert property (@(posedge clk) disable iff (rst)
        (is_rd && bus_addr[WIN_ADDR_W-1:2] == IDX_W'(1)) |=> bus_rdata == cfg_word(NUM_CORES));

    // R6: invalidate word reads zero
    a_r6_inv_zero: assert property (@(posedge clk) disable iff (rst)
        (is_rd && bus_addr[WIN_ADDR_W-1:2] == IDX_W'(3)) |=> bus_rdata == '0);

    // R7: flag follows unimplemented accesses
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        (bus_req && far) |=> unimp_pulse);
    a_r7_flag_clr: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && far) |=> !unimp_pulse);
    a_r7_far_zero: assert property (@(posedge clk) disable iff (rst)
        (is_rd && far) |=> bus_rdata == '0);

    // R9: read data holds when no read
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> $stable(bus_rdata));
endmodule

bind snp_regif snp_regif_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/snp_regif_tb.sv
module snp_regif_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        unimp_pulse;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_ctrl, m_pwr, m_rd;

    always #10 clk = ~clk;

    snp_regif #(.NUM_CORES(4)) u_dut (.*);

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a[7:2])
            6'd0: return m_ctrl;
            6'd1: return 32'h0000_00F3;
            6'd2: return m_pwr;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    // one access, then sample after the clock edge
    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        if (!we) m_rd = exp_read(a);
        if (we && a[7:2] == 6'd0) m_ctrl = d;
        if (we && a[7:2] == 6'd2) m_pwr = d;
        chk({tag, " flag R7"}, {31'b0, unimp_pulse}, {31'b0, a[7:2] >= 6'd4});
        chk({tag, " rdata R9"}, bus_rdata, m_rd);
    endtask

    initial begin
        void'($urandom(32'd4242));
        bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        m_ctrl = 0; m_pwr = 0; m_rd = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        chk("R1 flag after reset", {31'b0, unimp_pulse}, 32'h0);
        access(0, 8'h00, 0, "R1 ctrl");
        access(0, 8'h08, 0, "R1 pwr");
        access(0, 8'h04, 0, "R2 cfg");
        chk("R2 cfg value", bus_rdata, 32'h0000_00F3);
        access(1, 8'h04, 32'hDEAD_BEEF, "R3 cfg write");
        access(0, 8'h04, 0, "R3 cfg after write");
        access(0, 8'h00, 0, "R3 ctrl untouched");
        access(1, 8'h00, 32'hA5A5_1234, "R4 ctrl write");
        access(0, 8'h00, 0, "R4 ctrl read");
        chk("R4 ctrl value", bus_rdata, 32'hA5A5_1234);
        access(1, 8'h08, 32'h1111_2222, "R5 pwr write");
        access(1, 8'h0A, 32'hCAFE_0F0F, "R5 pwr write byte 2");
        access(0, 8'h09, 0, "R8 pwr read byte 1");
        chk("R5 pwr full replace", bus_rdata, 32'hCAFE_0F0F);
        access(0, 8'h03, 0, "R8 ctrl read byte 3");
        access(1, 8'h0C, 32'hFFFF_FFFF, "R6 inv write");
        access(0, 8'h0E, 0, "R6 inv read");
        chk("R6 inv zero", bus_rdata, 32'h0);
        access(0, 8'h00, 0, "R6 ctrl kept");
        access(0, 8'h08, 0, "R6 pwr kept");
        access(1, 8'h40, 32'h1234_5678, "R7 far write");
        chk("R7 flag high", {31'b0, unimp_pulse}, 32'h1);
        @(negedge clk);
        chk("R7 flag one cycle", {31'b0, unimp_pulse}, 32'h0);
        chk("R9 hold over write", bus_rdata, m_rd);
        access(0, 8'h40, 0, "R7 far read");
        chk("R7 far zero", bus_rdata, 32'h0);
        access(0, 8'hFF, 0, "R7 top of window");
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 16);
            access(1'($urandom), a, $urandom, "rand R5 R7 R8");
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                chk("rand idle R9", bus_rdata, m_rd);
                chk("rand idle R7", {31'b0, unimp_pulse}, 32'h0);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule